// File: doc/BRIEF.md
# Looping Multi-Setup Conversion Sequencer

This block is the digital control side of a multichannel converter running in its looping, multi-setup mode. Once a start command arrives, it walks through a programmed number of setups in ascending order. For each setup it asks an external conversion engine for a result over a request/done handshake, and it stores each 24-bit result in a small slot store. When the last setup of a set has been converted, the serial data-out line drops low to tell the host that a complete set is waiting.

The host drains the set over a three-wire serial port (SCLK, SDI, SDO, with an active-low select). It first clocks in one control byte, which clears the ready flag and decides whether looping goes on. It then clocks out every result in setup order. Two policies are available. In hold mode, the next set waits until the current one has been read in full. In free-run mode, conversions never pause, so an unread set is simply replaced by the next one.

The serial port is sampled in the system clock domain. SCLK, SDI and the select are expected to be synchronous to `clk`, and each SCLK level must last at least two `clk` cycles.

Top module: `mset_conv_seq`

## Requirements
- R1: The number of setups in a set is the 4-bit depth field plus one (1 to 16). The depth is captured when looping starts.
- R2: Within a set, setups are requested in ascending order starting at index 0 (the first setup), and the next set starts again at index 0. A request holds its setup index until done is seen.
- R3: The setup-select field of the start command has no effect: every accepted start begins at setup index 0.
- R4: While no unread set exists, SDO is high. After the final conversion of a set, SDO is low (outside a data readout) until the host's control byte completes.
- R5: A readout consists of 8 SCLKs carrying the control byte on SDI (MSB first, sampled on the SCLK rising edge), then 24 SCLKs per setup. Each result is sent MSB first in setup order, and SDO changes after the SCLK falling edge. The ready flag is cleared at the 8th rising edge.
- R6: Control byte 0xFF ends looping. The current set can still be read out, no further conversion is requested, a conversion already in flight is discarded, and `busy` falls once the readout has finished.
- R7: In hold mode (`cfg_wait`=1), no conversion is requested while a completed set is unread or being read. The next set begins after the last data bit has been clocked.
- R8: In free-run mode (`cfg_wait`=0), conversions continue without reads, and a newly completed set replaces the unread one.
- R9: In free-run mode, when a new set completes while an earlier set is still unread, SDO goes high for one `clk` cycle and then low again.
- R10: A start command is ignored unless both `cfg_loop` and `cfg_multi` are 1, and it is also ignored while `busy` is high.
- R11: Control byte 0x00, and any byte other than 0xFF, keeps looping running.
- R12: During the data part of a readout, SDO carries result bits. SDO goes back to showing the ready flag right after the last data bit, so it reads high if no newer set has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_loop | input | 1 | Looping conversion enable |
| cfg_multi | input | 1 | Multi-setup enable |
| cfg_wait | input | 1 | 1: hold for readout, 0: free-run with overwrite |
| cfg_depth | input | 4 | Setups per set minus one |
| start_cmd | input | 1 | Start-convert command strobe (one cycle) |
| start_sel | input | 3 | Setup-select field of the command (ignored) |
| conv_req | output | 1 | Conversion request, held until done |
| conv_setup | output | 4 | Setup index of the current request |
| conv_done | input | 1 | Conversion finished, result valid (one cycle) |
| conv_data | input | 24 | Conversion result |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low serial select |
| sdo | output | 1 | Serial data / ready flag |
| busy | output | 1 | Looping active or final readout pending |

## Verification
The assertions assume several things about the inputs. The conversion engine pulses `conv_done` only while a request is pending and never in two adjacent cycles. The host begins a readout only after SDO has fallen. SCLK levels last several clock cycles. The bench keeps to these assumptions: its converter model answers after a random delay of at least two cycles, and its host tasks wait for the set to be flagged and hold each SCLK phase for four cycles. In free-run tests the conversion delay is long enough that the data being read is never overwritten mid-read.

// File: rtl/mset_conv_pkg.sv
package mset_conv_pkg;
    localparam int CTRL_BITS = 8;
    localparam logic [CTRL_BITS-1:0] CTRL_EXIT = 8'hFF;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_BUSY,
        ENG_HOLD,
        ENG_DRAIN
    } eng_state_t;

    typedef enum logic [1:0] {
        SP_IDLE,
        SP_CMD,
        SP_DATA
    } sp_state_t;
endpackage

// File: rtl/mset_seq_engine.sv
module mset_seq_engine
    import mset_conv_pkg::*;
#(
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_loop,
    input  logic               cfg_multi,
    input  logic               cfg_wait,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic               start_cmd,
    input  logic               stop_req,
    input  logic               read_done,
    input  logic               rd_active,
    input  logic               conv_done,
    output logic               conv_req,
    output logic [DEPTH_W-1:0] conv_setup,
    output logic               wr_en,
    output logic               set_done,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               busy
);
    typedef struct packed {
        eng_state_t         st;
        logic [DEPTH_W-1:0] idx;
        logic [DEPTH_W-1:0] depth;
        logic               waitm;
        logic               stop;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d        = q;
        wr_en    = 1'b0;
        set_done = 1'b0;
        case (q.st)
            ENG_IDLE: begin
                if (start_cmd && cfg_loop && cfg_multi) begin
                    d.st    = ENG_BUSY;
                    d.idx   = '0;
                    d.depth = cfg_depth;
                    d.waitm = cfg_wait;
                    d.stop  = 1'b0;
                end
            end
            ENG_BUSY: begin
                if (stop_req) d.stop = 1'b1;
                if (conv_done) begin
                    if (q.stop || stop_req) begin
                        d.st = ENG_DRAIN;
                    end else begin
                        wr_en = 1'b1;
                        if (q.idx == q.depth) begin
                            set_done = 1'b1;
                            d.idx    = '0;
                            d.st     = q.waitm ? ENG_HOLD : ENG_BUSY;
                        end else begin
                            d.idx = q.idx + DEPTH_W'(1);
                        end
                    end
                end
            end
            ENG_HOLD: begin
                if (stop_req)       d.st = ENG_DRAIN;
                else if (read_done) d.st = ENG_BUSY;
            end
            ENG_DRAIN: begin
                if (!rd_active) d.st = ENG_IDLE;
            end
            default: d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ENG_IDLE, idx: '0, depth: '0, waitm: 1'b0, stop: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign conv_req   = (q.st == ENG_BUSY);
    assign conv_setup = q.idx;
    assign depth_o    = q.depth;
    assign busy       = (q.st != ENG_IDLE);

    // R1: a request never names a setup beyond the captured depth
    p_setup_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> conv_setup <= q.depth);

    // R2: an outstanding request keeps its setup index
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_done) |=> (conv_req && $stable(conv_setup)));

    // R2: after a non-final result the next request is the next setup
    p_next_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && conv_done && !q.stop && !stop_req && conv_setup != q.depth)
        |=> (conv_req && conv_setup == $past(conv_setup) + DEPTH_W'(1)));

    // R7: hold mode never converts while the host is reading
    p_wait_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.waitm && rd_active) |-> !conv_req);

    // R10: start without loop and multi mode leaves the engine idle
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ENG_IDLE && start_cmd && !(cfg_loop && cfg_multi)) |=> !conv_req);
endmodule

// File: rtl/mset_serial_port.sv
module mset_serial_port
    import mset_conv_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               sdi,
    input  logic               cs_n,
    input  logic               set_done,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [WORD_W-1:0]  rd_word,
    output logic [DEPTH_W-1:0] rd_idx,
    output logic               stop_req,
    output logic               read_done,
    output logic               rd_active,
    output logic               sdo
);
    localparam int CNT_W = $clog2(WORD_W);

    typedef struct packed {
        sp_state_t            ph;
        logic                 sclk_q;
        logic                 rdy;
        logic                 pulse;
        logic                 sdo_bit;
        logic [CTRL_BITS-1:0] shreg;
        logic [CNT_W-1:0]     bcnt;
        logic [DEPTH_W-1:0]   widx;
    } sp_t;

    sp_t q, d;
    logic                 rise, fall;
    logic [CTRL_BITS-1:0] byte_in;
    logic [WORD_W-1:0]    shw;

    assign rise    = !cs_n && sclk && !q.sclk_q;
    assign fall    = !cs_n && !sclk && q.sclk_q;
    assign byte_in = {q.shreg[CTRL_BITS-2:0], sdi};
    assign shw     = rd_word << q.bcnt;

    always_comb begin
        d         = q;
        stop_req  = 1'b0;
        read_done = 1'b0;
        d.sclk_q  = sclk;
        d.pulse   = 1'b0;
        case (q.ph)
            SP_IDLE: begin
                if (q.rdy && rise) begin
                    d.shreg = byte_in;
                    d.bcnt  = CNT_W'(1);
                    d.ph    = SP_CMD;
                end
            end
            SP_CMD: begin
                if (rise) begin
                    d.shreg = byte_in;
                    if (q.bcnt == CNT_W'(CTRL_BITS - 1)) begin
                        d.ph     = SP_DATA;
                        d.rdy    = 1'b0;
                        d.bcnt   = '0;
                        d.widx   = '0;
                        stop_req = (byte_in == CTRL_EXIT);
                    end else begin
                        d.bcnt = q.bcnt + CNT_W'(1);
                    end
                end
            end
            SP_DATA: begin
                if (fall) d.sdo_bit = shw[WORD_W-1];
                if (rise) begin
                    if (q.bcnt == CNT_W'(WORD_W - 1)) begin
                        d.bcnt = '0;
                        if (q.widx == depth) begin
                            d.ph      = SP_IDLE;
                            read_done = 1'b1;
                        end else begin
                            d.widx = q.widx + DEPTH_W'(1);
                        end
                    end else begin
                        d.bcnt = q.bcnt + CNT_W'(1);
                    end
                end
            end
            default: d.ph = SP_IDLE;
        endcase
        if (set_done) begin
            d.rdy   = 1'b1;
            d.pulse = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: SP_IDLE, sclk_q: 1'b0, rdy: 1'b0, pulse: 1'b0,
                   sdo_bit: 1'b0, shreg: '0, bcnt: '0, widx: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_idx    = q.widx;
    assign rd_active = (q.ph != SP_IDLE);
    assign sdo       = (q.ph == SP_DATA) ? q.sdo_bit : (!q.rdy || q.pulse);

    // R4: a set completing outside a readout shows SDO low two cycles later
    p_flag_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_done && q.ph == SP_IDLE) |-> ##2 !sdo);

    // R12: after the last data bit the port is idle and shows the flag
    p_flag_back_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (read_done && !set_done && !q.pulse) |=> (sdo && !rd_active));
endmodule

// File: rtl/mset_conv_seq.sv
module mset_conv_seq
    import mset_conv_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int DEPTH_W = 4,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_loop,
    input  logic               cfg_multi,
    input  logic               cfg_wait,
    input  logic [DEPTH_W-1:0] cfg_depth,
    input  logic               start_cmd,
    input  logic [SEL_W-1:0]   start_sel,
    output logic               conv_req,
    output logic [DEPTH_W-1:0] conv_setup,
    input  logic               conv_done,
    input  logic [WORD_W-1:0]  conv_data,
    input  logic               sclk,
    input  logic               sdi,
    input  logic               cs_n,
    output logic               sdo,
    output logic               busy
);
    localparam int SLOTS = 1 << DEPTH_W;

    logic               wr_en, set_done, stop_req, read_done, rd_active;
    logic [DEPTH_W-1:0] depth_q, rd_idx;
    logic [WORD_W-1:0]  slot_q [SLOTS];
    logic               unused_sel;

    assign unused_sel = ^start_sel;

    mset_seq_engine #(.DEPTH_W(DEPTH_W)) eng_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_loop(cfg_loop), .cfg_multi(cfg_multi), .cfg_wait(cfg_wait),
        .cfg_depth(cfg_depth), .start_cmd(start_cmd),
        .stop_req(stop_req), .read_done(read_done), .rd_active(rd_active),
        .conv_done(conv_done), .conv_req(conv_req), .conv_setup(conv_setup),
        .wr_en(wr_en), .set_done(set_done), .depth_o(depth_q), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (wr_en) slot_q[conv_setup] <= conv_data;
    end

    mset_serial_port #(.WORD_W(WORD_W), .DEPTH_W(DEPTH_W)) port_i (
        .clk(clk), .rst_n(rst_n),
        .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .set_done(set_done), .depth(depth_q), .rd_word(slot_q[rd_idx]),
        .rd_idx(rd_idx), .stop_req(stop_req), .read_done(read_done),
        .rd_active(rd_active), .sdo(sdo)
    );
endmodule

// File: tb/mset_conv_seq_tb.sv
module mset_conv_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_loop = 1'b0, cfg_multi = 1'b0, cfg_wait = 1'b0;
    logic [3:0]  cfg_depth = '0;
    logic        start_cmd = 1'b0;
    logic [2:0]  start_sel = '0;
    logic        conv_req;
    logic [3:0]  conv_setup;
    logic        conv_done = 1'b0;
    logic [23:0] conv_data = '0;
    logic        sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
    logic        sdo, busy;

    always #5 clk = ~clk;

    mset_conv_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_loop(cfg_loop), .cfg_multi(cfg_multi),
        .cfg_wait(cfg_wait), .cfg_depth(cfg_depth), .start_cmd(start_cmd),
        .start_sel(start_sel), .conv_req(conv_req), .conv_setup(conv_setup),
        .conv_done(conv_done), .conv_data(conv_data), .sclk(sclk), .sdi(sdi),
        .cs_n(cs_n), .sdo(sdo), .busy(busy)
    );

    int checks = 0, fails = 0;
    int conv_delay = 4, conv_count = 0, set_cnt = 0, exp_next = 0;
    int cur_depth = 0, seq_err = 0, set_size = 0, last_size = 0, rises = 0;
    bit reading = 1'b0;
    logic [23:0] model_slot [16];
    logic [23:0] exp_set [16];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] conv_value(input logic [3:0] s, input int n);
        return {s, n[19:0]};
    endfunction

    // conversion engine model
    initial begin
        bit pend = 1'b0;
        int cnt = 0;
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            if (pend) begin
                if (cnt <= 1) begin
                    pend = 1'b0;
                    conv_count++;
                    conv_data = conv_value(conv_setup, conv_count);
                    conv_done = 1'b1;
                    model_slot[conv_setup] = conv_data;
                    if (int'(conv_setup) != exp_next) seq_err++;
                    set_size++;
                    if (int'(conv_setup) == cur_depth) begin
                        exp_next = 0;
                        for (int i = 0; i < 16; i++) exp_set[i] = model_slot[i];
                        last_size = set_size;
                        set_size = 0;
                        set_cnt++;
                    end else begin
                        exp_next = int'(conv_setup) + 1;
                    end
                end else begin
                    cnt--;
                end
            end else if (conv_req && rst_n) begin
                pend = 1'b1;
                cnt = conv_delay;
            end
        end
    end

    // SDO rise monitor outside readouts
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!reading && sdo && !prev) rises++;
            prev = sdo;
        end
    end

    task automatic sbit(input logic din, output logic dout);
        @(negedge clk);
        sdi = din;
        repeat (4) @(negedge clk);
        dout = sdo;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic read_set(input logic [7:0] ctl, input int n, output int bad);
        logic x;
        logic [23:0] w;
        bad = 0;
        reading = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < 8; i++) sbit(ctl[7-i], x);
        for (int k = 0; k < n; k++) begin
            w = '0;
            for (int b = 0; b < 24; b++) begin
                sbit(1'b0, x);
                w = {w[22:0], x};
            end
            if (w !== exp_set[k]) begin
                bad++;
                $display("  word %0d got %0h want %0h", k, w, exp_set[k]);
            end
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        reading = 1'b0;
    endtask

    task automatic wait_set(input int target, input string req);
        int t = 0;
        while (set_cnt < target && t < 30000) begin
            @(negedge clk);
            t++;
        end
        chk(set_cnt >= target, req, "set completion timeout", set_cnt, target);
        repeat (3) @(negedge clk);
    endtask

    task automatic start_loop(input int depth, input bit waitm, input int dly);
        @(negedge clk);
        cfg_loop = 1'b1; cfg_multi = 1'b1; cfg_wait = waitm;
        cfg_depth = 4'(depth); cur_depth = depth; exp_next = 0;
        set_size = 0; conv_delay = dly;
        start_sel = 3'($urandom_range(1, 7));
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(!busy, req, "busy after exit readout", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int bad, base, t;
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(sdo === 1'b1, "R4", "sdo at reset", sdo, 1);
        chk(conv_req === 1'b0 && busy === 1'b0, "R10", "idle at reset", {conv_req, busy}, 0);

        // R10: start ignored without loop or multi mode
        @(negedge clk); cfg_loop = 1'b1; cfg_multi = 1'b0; start_cmd = 1'b1;
        @(negedge clk); start_cmd = 1'b0;
        repeat (30) @(negedge clk);
        chk(!conv_req && !busy, "R10", "start with multi=0", {conv_req, busy}, 0);
        @(negedge clk); cfg_loop = 1'b0; cfg_multi = 1'b1; start_cmd = 1'b1;
        @(negedge clk); start_cmd = 1'b0;
        repeat (30) @(negedge clk);
        chk(!conv_req && !busy, "R10", "start with loop=0", {conv_req, busy}, 0);

        // directed hold mode, depth 3
        start_loop(3, 1'b1, 5);
        @(negedge clk);
        chk(conv_req && conv_setup == 4'd0, "R3", "first setup despite select", conv_setup, 0);
        wait_set(1, "R4");
        chk(sdo === 1'b0, "R4", "sdo low when set ready", sdo, 0);
        chk(last_size == 4, "R1", "setups per set depth 3", last_size, 4);
        base = conv_count;
        repeat (300) @(negedge clk);
        chk(conv_count == base && !conv_req, "R7", "no conversion while unread", conv_count, base);
        read_set(8'h00, 4, bad);
        chk(bad == 0, "R5", "readout data depth 3", bad, 0);
        chk(sdo === 1'b1, "R12", "flag back high after readout", sdo, 1);
        t = 0;
        while (!conv_req && t < 50) begin @(negedge clk); t++; end
        chk(conv_req && conv_setup == 4'd0, "R7", "next set starts after read", {conv_req, conv_setup}, 5'h10);
        wait_set(2, "R11");
        read_set(8'h5A, 4, bad);
        chk(bad == 0, "R11", "readout after odd control byte", bad, 0);
        wait_set(3, "R11");
        chk(sdo === 1'b0, "R11", "looping continued after 0x5A", sdo, 0);
        read_set(8'hFF, 4, bad);
        chk(bad == 0, "R6", "final readout data", bad, 0);
        wait_idle("R6");
        base = conv_count;
        repeat (500) @(negedge clk);
        chk(conv_count == base && !conv_req, "R6", "no conversions after exit", conv_count, base);

        // random hold-mode runs, including depth 0 and 15
        for (int it = 0; it < 6; it++) begin
            int dep, s0;
            logic [7:0] cb;
            dep = (it == 0) ? 0 : (it == 1) ? 15 : $urandom_range(0, 15);
            s0 = set_cnt;
            start_loop(dep, 1'b1, $urandom_range(2, 20));
            for (int s = 0; s < 2; s++) begin
                wait_set(s0 + s + 1, "R1");
                chk(last_size == dep + 1, "R1", "setups per set", last_size, dep + 1);
                cb = (s == 1) ? 8'hFF : 8'($urandom_range(0, 254));
                read_set(cb, dep + 1, bad);
                chk(bad == 0, "R5", "random readout data", bad, 0);
            end
            wait_idle("R6");
        end
        chk(seq_err == 0, "R2", "setup order errors", seq_err, 0);

        // free-run mode with overwrite
        begin
            int s0;
            s0 = set_cnt;
            start_loop(2, 1'b0, 400);
            wait_set(s0 + 1, "R8");
            rises = 0;
            wait_set(s0 + 2, "R8");
            chk(rises == 1, "R9", "sdo pulse on replaced set", rises, 1);
            chk(sdo === 1'b0, "R9", "sdo low after pulse", sdo, 0);
            read_set(8'h00, 3, bad);
            chk(bad == 0, "R8", "newer set replaced unread one", bad, 0);
            wait_set(s0 + 3, "R8");
            read_set(8'hFF, 3, bad);
            chk(bad == 0, "R6", "free-run exit readout", bad, 0);
            wait_idle("R6");
            base = conv_count;
            repeat (1000) @(negedge clk);
            chk(conv_count == base && !conv_req, "R6", "free-run stopped", conv_count, base);
        end
        chk(seq_err == 0, "R2", "setup order errors final", seq_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule